// File: doc/BRIEF.md
# Masked-Tag Translation Buffer with Paired Frames

This block is a small fully associative translation buffer for a processor's memory front end. Each slot holds a virtual page tag, a per-slot page mask, an address-space tag and a global flag. It also holds two frame halves, even and odd. Each half carries a frame number, a 3-bit cache attribute, a dirty bit and a valid bit. A lookup presents a virtual address and the current address-space tag. All slots are compared in parallel. One cycle later the block returns hit, the slot index and the frame data of the selected half. The same response serves as a probe result, because a miss reports an all-ones index.

Software-side maintenance uses two operations. An indexed write replaces one slot. A flush empties every slot. A readback port returns a slot's contents packed into fixed word layouts. Every lookup response also carries an uncacheable flag, which is taken directly from the virtual address. Walking page tables, raising faults and choosing victims are left to the surrounding logic.

Top module: `tlb_assoc`

## Requirements
- R1: A slot's tag matches the lookup tag (virtual address bits above PAGE_SHIFT+1) when the two agree on every bit that is clear in that slot's page mask. Bits set in the mask are don't-care.
- R2: A matching tag also needs the slot's global flag set, or the slot's address-space tag equal to the lookup's.
- R3: When several slots match, the lowest-numbered one is reported.
- R4: `rsp_idx` is the matching slot number with a leading zero bit. On a miss it is all ones, 4'hF with default parameters.
- R5: The lowest virtual address bit above the masked region picks the half. With k low ones in the mask this is bit PAGE_SHIFT+k: 0 picks even, 1 picks odd. `rsp_pfn`, `rsp_cat`, `rsp_dty` and `rsp_pv` come from the picked half, and they are all zero on a miss.
- R6: A write with `wr_idx` at or above ENTRIES changes no slot. This includes the slot its low bits would name.
- R7: A flush empties every slot. A write in the same cycle as a flush is discarded.
- R8: A slot with both half-valid bits clear never matches. Reset empties all slots.
- R9: `rsp_unc` is 1 exactly when virtual address bits 31 and 29 (mask 32'hA000_0000) are both set, whether or not the lookup hits.
- R10: Readback one cycle after `rd_req` returns the following words.
  - `rb_mask` is the mask shifted left 11.
  - `rb_tag` is the tag shifted left 11, with the address-space tag in the low bits.
  - `rb_even` and `rb_odd` each hold the frame number from bit 6 up, the cache attribute at bits 5:3, dirty at bit 2, valid at bit 1 and global at bit 0.
  - An index at or above ENTRIES reads as all zeros.
- R11: `rsp_vld` is high in the cycle after a cycle with `lk_req` high, and low otherwise. The response fields hold between lookups.
- R12: A write into an occupied slot replaces it completely, so the old mapping stops matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup strobe |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Current address-space tag |
| wr_en | input | 1 | Indexed write strobe |
| wr_idx | input | IDX_W+1 | Slot to write |
| wr_vpn | input | VPN_W | New tag |
| wr_mask | input | VPN_W | New page mask |
| wr_asid | input | ASID_W | New address-space tag |
| wr_glob | input | 1 | New global flag |
| wr_pfn_e | input | PFN_W | Even frame number |
| wr_pfn_o | input | PFN_W | Odd frame number |
| wr_cat_e | input | 3 | Even cache attribute |
| wr_cat_o | input | 3 | Odd cache attribute |
| wr_dty_e | input | 1 | Even dirty |
| wr_dty_o | input | 1 | Odd dirty |
| wr_vld_e | input | 1 | Even valid |
| wr_vld_o | input | 1 | Odd valid |
| flush | input | 1 | Empty all slots |
| rd_req | input | 1 | Readback strobe |
| rd_idx | input | IDX_W+1 | Slot to read back |
| rsp_vld | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_idx | output | IDX_W+1 | Matching slot, all ones on miss |
| rsp_pfn | output | PFN_W | Frame of picked half |
| rsp_cat | output | 3 | Cache attribute of picked half |
| rsp_dty | output | 1 | Dirty of picked half |
| rsp_pv | output | 1 | Valid of picked half |
| rsp_unc | output | 1 | Uncacheable region flag |
| rb_vld | output | 1 | Readback valid |
| rb_mask | output | VPN_W+11 | Packed mask word |
| rb_tag | output | VPN_W+11 | Packed tag and address-space word |
| rb_even | output | PFN_W+6 | Packed even half |
| rb_odd | output | PFN_W+6 | Packed odd half |

## Verification
The following are checked on every cycle:
- the one-cycle response timing;
- that a hit carries an in-range index and a miss carries all ones with zeroed frame fields;
- that a lookup just after a flush misses;
- that the uncacheable flag follows the address bits.

The bench scenarios are needed for the rest:
- masked compare and the address-space/global rule;
- lowest-index priority between overlapping slots;
- half selection at a wide mask;
- rejected out-of-range writes that would alias a live slot;
- flush beating a simultaneous write;
- slot replacement;
- the readback bit layout.

// File: rtl/tlb_assoc_pkg.sv
package tlb_assoc_pkg;
   // left shift of mask and tag in the readback words
   localparam int RB_SHIFT = 11;
   // cache attribute width per frame half
   localparam int CAT_W = 3;
   // low attribute bits under the frame number in a packed half word
   localparam int HALF_LOW_W = CAT_W + 3;

   typedef struct packed {
      logic [CAT_W-1:0] cat;
      logic             dty;
      logic             vld;
   } half_attr_t;
endpackage

// File: rtl/tlb_slot_bank.sv
module tlb_slot_bank
   import tlb_assoc_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 19,
   parameter int ASID_W  = 8,
   parameter int PFN_W   = 20,
   parameter int WIDX_W  = 4
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   flush,
   input  logic                                   wr_en,
   input  logic [WIDX_W-1:0]                      wr_idx,
   input  logic [VPN_W-1:0]                       wr_vpn,
   input  logic [VPN_W-1:0]                       wr_mask,
   input  logic [ASID_W-1:0]                      wr_asid,
   input  logic                                   wr_glob,
   input  logic [1:0][PFN_W-1:0]                  wr_pfn,
   input  half_attr_t [1:0]                       wr_attr,
   output logic [ENTRIES-1:0][VPN_W-1:0]          s_vpn,
   output logic [ENTRIES-1:0][VPN_W-1:0]          s_mask,
   output logic [ENTRIES-1:0][ASID_W-1:0]         s_asid,
   output logic [ENTRIES-1:0]                     s_glob,
   output logic [ENTRIES-1:0][1:0][PFN_W-1:0]     s_pfn,
   output half_attr_t [ENTRIES-1:0][1:0]          s_attr
);
   // one register set per slot; the write compare uses the full index width
   // so an out-of-range index selects nothing
   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_idx == WIDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_vpn[i]  <= '0;
            s_mask[i] <= '0;
            s_asid[i] <= '0;
            s_glob[i] <= 1'b0;
            s_pfn[i]  <= '0;
            s_attr[i] <= '0;
         end else if (flush) begin
            s_vpn[i]  <= '0;
            s_mask[i] <= '0;
            s_asid[i] <= '0;
            s_glob[i] <= 1'b0;
            s_pfn[i]  <= '0;
            s_attr[i] <= '0;
         end else if (sel) begin
            s_vpn[i]  <= wr_vpn;
            s_mask[i] <= wr_mask;
            s_asid[i] <= wr_asid;
            s_glob[i] <= wr_glob;
            s_pfn[i]  <= wr_pfn;
            s_attr[i] <= wr_attr;
         end
      end
   end
endmodule

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp #(
   parameter int VPN_W  = 19,
   parameter int ASID_W = 8
) (
   input  logic [VPN_W-1:0]  q_vpn,
   input  logic [ASID_W-1:0] q_asid,
   input  logic [VPN_W-1:0]  e_vpn,
   input  logic [VPN_W-1:0]  e_mask,
   input  logic [ASID_W-1:0] e_asid,
   input  logic              e_glob,
   input  logic              e_occ,
   output logic              match
);
   logic tag_ok;
   logic space_ok;

   assign tag_ok   = (((q_vpn ^ e_vpn) & ~e_mask) == '0);
   assign space_ok = e_glob || (q_asid == e_asid);
   assign match    = e_occ && tag_ok && space_ok;
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 3
) (
   input  logic [ENTRIES-1:0] match,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   // scan from the top so the lowest matching slot is written last
   always_comb begin
      idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) idx = IDX_W'(i);
      end
   end
   assign any = |match;
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
   import tlb_assoc_pkg::*;
#(
   parameter int          ENTRIES    = 8,
   parameter int          VA_W       = 32,
   parameter int          PAGE_SHIFT = 12,
   parameter int          ASID_W     = 8,
   parameter int          PFN_W      = 20,
   parameter bit          UNC_EN     = 1'b1,
   parameter logic [31:0] UNC_MASK   = 32'hA000_0000,
   localparam int         VPN_W      = VA_W - PAGE_SHIFT - 1,
   localparam int         IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int         WIDX_W     = IDX_W + 1,
   localparam int         RBW_W      = VPN_W + RB_SHIFT,
   localparam int         RBH_W      = PFN_W + HALF_LOW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              wr_en,
   input  logic [WIDX_W-1:0] wr_idx,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [VPN_W-1:0]  wr_mask,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_glob,
   input  logic [PFN_W-1:0]  wr_pfn_e,
   input  logic [PFN_W-1:0]  wr_pfn_o,
   input  logic [CAT_W-1:0]  wr_cat_e,
   input  logic [CAT_W-1:0]  wr_cat_o,
   input  logic              wr_dty_e,
   input  logic              wr_dty_o,
   input  logic              wr_vld_e,
   input  logic              wr_vld_o,
   input  logic              flush,
   input  logic              rd_req,
   input  logic [WIDX_W-1:0] rd_idx,
   output logic              rsp_vld,
   output logic              rsp_hit,
   output logic [WIDX_W-1:0] rsp_idx,
   output logic [PFN_W-1:0]  rsp_pfn,
   output logic [CAT_W-1:0]  rsp_cat,
   output logic              rsp_dty,
   output logic              rsp_pv,
   output logic              rsp_unc,
   output logic              rb_vld,
   output logic [RBW_W-1:0]  rb_mask,
   output logic [RBW_W-1:0]  rb_tag,
   output logic [RBH_W-1:0]  rb_even,
   output logic [RBH_W-1:0]  rb_odd
);
   // elaboration checks on the parameter set
   if (ENTRIES < 2) begin : g_bad_entries
      $error("tlb_assoc: ENTRIES must be at least 2");
   end
   if (VPN_W < 1) begin : g_bad_va
      $error("tlb_assoc: VA_W too small for PAGE_SHIFT");
   end
   if (ASID_W > RB_SHIFT) begin : g_bad_asid
      $error("tlb_assoc: ASID_W must fit under the readback shift");
   end
   if (UNC_EN && (VA_W != 32)) begin : g_bad_unc
      $error("tlb_assoc: uncacheable decode assumes a 32-bit address");
   end

   // ---------------- storage ----------------
   logic [ENTRIES-1:0][VPN_W-1:0]      s_vpn;
   logic [ENTRIES-1:0][VPN_W-1:0]      s_mask;
   logic [ENTRIES-1:0][ASID_W-1:0]     s_asid;
   logic [ENTRIES-1:0]                 s_glob;
   logic [ENTRIES-1:0][1:0][PFN_W-1:0] s_pfn;
   half_attr_t [ENTRIES-1:0][1:0]      s_attr;
   logic [1:0][PFN_W-1:0]              in_pfn;
   half_attr_t [1:0]                   in_attr;

   assign in_pfn[0]  = wr_pfn_e;
   assign in_pfn[1]  = wr_pfn_o;
   assign in_attr[0] = '{cat: wr_cat_e, dty: wr_dty_e, vld: wr_vld_e};
   assign in_attr[1] = '{cat: wr_cat_o, dty: wr_dty_o, vld: wr_vld_o};

   tlb_slot_bank #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .ASID_W  (ASID_W),
      .PFN_W   (PFN_W),
      .WIDX_W  (WIDX_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_vpn  (wr_vpn),
      .wr_mask (wr_mask),
      .wr_asid (wr_asid),
      .wr_glob (wr_glob),
      .wr_pfn  (in_pfn),
      .wr_attr (in_attr),
      .s_vpn   (s_vpn),
      .s_mask  (s_mask),
      .s_asid  (s_asid),
      .s_glob  (s_glob),
      .s_pfn   (s_pfn),
      .s_attr  (s_attr)
   );

   // ---------------- parallel compare ----------------
   logic [VPN_W-1:0]   q_vpn;
   logic [VPN_W:0]     q_page;
   logic [ENTRIES-1:0] match;

   assign q_vpn  = lk_va[VA_W-1:PAGE_SHIFT+1];
   assign q_page = lk_va[VA_W-1:PAGE_SHIFT];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      tlb_tag_cmp #(
         .VPN_W  (VPN_W),
         .ASID_W (ASID_W)
      ) u_cmp (
         .q_vpn  (q_vpn),
         .q_asid (lk_asid),
         .e_vpn  (s_vpn[i]),
         .e_mask (s_mask[i]),
         .e_asid (s_asid[i]),
         .e_glob (s_glob[i]),
         .e_occ  (s_attr[i][0].vld || s_attr[i][1].vld),
         .match  (match[i])
      );
   end

   logic             f_any;
   logic [IDX_W-1:0] f_idx;

   tlb_first_hit #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W)
   ) u_first (
      .match (match),
      .any   (f_any),
      .idx   (f_idx)
   );

   // ---------------- half select ----------------
   // the bit just above the low run of mask ones picks the odd half
   logic [VPN_W:0] run_ext;
   logic [VPN_W:0] pick_bit;
   logic           odd;
   half_attr_t     sel_attr;
   logic [PFN_W-1:0] sel_pfn;

   assign run_ext  = {1'b0, s_mask[f_idx]};
   assign pick_bit = (run_ext + 1'b1) & ~run_ext;
   assign odd      = |(q_page & pick_bit);
   assign sel_attr = s_attr[f_idx][odd];
   assign sel_pfn  = s_pfn[f_idx][odd];

   // ---------------- uncacheable decode ----------------
   logic unc_now;
   if (UNC_EN) begin : g_unc
      assign unc_now = ((32'(lk_va) & UNC_MASK) == UNC_MASK);
   end else begin : g_no_unc
      assign unc_now = 1'b0;
   end

   // ---------------- lookup response ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld <= 1'b0;
         rsp_hit <= 1'b0;
         rsp_idx <= '1;
         rsp_pfn <= '0;
         rsp_cat <= '0;
         rsp_dty <= 1'b0;
         rsp_pv  <= 1'b0;
         rsp_unc <= 1'b0;
      end else begin
         rsp_vld <= lk_req;
         if (lk_req) begin
            rsp_hit <= f_any;
            rsp_idx <= f_any ? {1'b0, f_idx} : '1;
            rsp_pfn <= f_any ? sel_pfn : '0;
            rsp_cat <= f_any ? sel_attr.cat : '0;
            rsp_dty <= f_any && sel_attr.dty;
            rsp_pv  <= f_any && sel_attr.vld;
            rsp_unc <= unc_now;
         end
      end
   end

   // ---------------- readback ----------------
   logic             rd_in;
   logic [IDX_W-1:0] rd_slot;

   assign rd_in   = (rd_idx < WIDX_W'(ENTRIES));
   assign rd_slot = rd_idx[IDX_W-1:0];

   function automatic logic [RBH_W-1:0] pack_half(input logic [PFN_W-1:0] pfn,
                                                  input half_attr_t a,
                                                  input logic g);
      return {pfn, a.cat, a.dty, a.vld, g};
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rb_vld  <= 1'b0;
         rb_mask <= '0;
         rb_tag  <= '0;
         rb_even <= '0;
         rb_odd  <= '0;
      end else begin
         rb_vld <= rd_req;
         if (rd_req) begin
            if (rd_in) begin
               rb_mask <= {s_mask[rd_slot], RB_SHIFT'(0)};
               rb_tag  <= {s_vpn[rd_slot], RB_SHIFT'(0)} | RBW_W'(s_asid[rd_slot]);
               rb_even <= pack_half(s_pfn[rd_slot][0], s_attr[rd_slot][0], s_glob[rd_slot]);
               rb_odd  <= pack_half(s_pfn[rd_slot][1], s_attr[rd_slot][1], s_glob[rd_slot]);
            end else begin
               rb_mask <= '0;
               rb_tag  <= '0;
               rb_even <= '0;
               rb_odd  <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
   parameter int          ENTRIES  = 8,
   parameter int          VA_W     = 32,
   parameter int          WIDX_W   = 4,
   parameter int          PFN_W    = 20,
   parameter bit          UNC_EN   = 1'b1,
   parameter logic [31:0] UNC_MASK = 32'hA000_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_req,
   input logic [VA_W-1:0]   lk_va,
   input logic              flush,
   input logic              rsp_vld,
   input logic              rsp_hit,
   input logic [WIDX_W-1:0] rsp_idx,
   input logic [PFN_W-1:0]  rsp_pfn,
   input logic              rsp_pv,
   input logic              rsp_unc
);
   // R11
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> rsp_vld);

   // R11
   rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !rsp_vld);

   // R4
   miss_idx_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && !rsp_hit) |-> (rsp_idx == '1));

   // R4
   hit_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_hit) |-> (rsp_idx < WIDX_W'(ENTRIES)));

   // R5
   miss_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && !rsp_hit) |-> (rsp_pfn == '0 && !rsp_pv));

   // R7
   flush_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flush) && lk_req) |=> !rsp_hit);

   // R9
   unc_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (UNC_EN && lk_req) |=> (rsp_unc == (($past(32'(lk_va)) & UNC_MASK) == UNC_MASK)));
endmodule

bind tlb_assoc tlb_assoc_chk #(
   .ENTRIES  (ENTRIES),
   .VA_W     (VA_W),
   .WIDX_W   (WIDX_W),
   .PFN_W    (PFN_W),
   .UNC_EN   (UNC_EN),
   .UNC_MASK (UNC_MASK)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .lk_req  (lk_req),
   .lk_va   (lk_va),
   .flush   (flush),
   .rsp_vld (rsp_vld),
   .rsp_hit (rsp_hit),
   .rsp_idx (rsp_idx),
   .rsp_pfn (rsp_pfn),
   .rsp_pv  (rsp_pv),
   .rsp_unc (rsp_unc)
);

// File: tb/tb_tlb_assoc.sv
`timescale 1ns/1ps
module tb_tlb_assoc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_req = 1'b0;
   logic [31:0] lk_va = '0;
   logic [7:0]  lk_asid = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [18:0] wr_vpn = '0;
   logic [18:0] wr_mask = '0;
   logic [7:0]  wr_asid = '0;
   logic        wr_glob = 1'b0;
   logic [19:0] wr_pfn_e = '0;
   logic [19:0] wr_pfn_o = '0;
   logic [2:0]  wr_cat_e = '0;
   logic [2:0]  wr_cat_o = '0;
   logic        wr_dty_e = 1'b0;
   logic        wr_dty_o = 1'b0;
   logic        wr_vld_e = 1'b0;
   logic        wr_vld_o = 1'b0;
   logic        flush = 1'b0;
   logic        rd_req = 1'b0;
   logic [3:0]  rd_idx = '0;
   logic        rsp_vld, rsp_hit, rsp_dty, rsp_pv, rsp_unc, rb_vld;
   logic [3:0]  rsp_idx;
   logic [19:0] rsp_pfn;
   logic [2:0]  rsp_cat;
   logic [29:0] rb_mask, rb_tag;
   logic [25:0] rb_even, rb_odd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tlb_assoc dut (
      .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
      .wr_asid(wr_asid), .wr_glob(wr_glob), .wr_pfn_e(wr_pfn_e), .wr_pfn_o(wr_pfn_o),
      .wr_cat_e(wr_cat_e), .wr_cat_o(wr_cat_o), .wr_dty_e(wr_dty_e), .wr_dty_o(wr_dty_o),
      .wr_vld_e(wr_vld_e), .wr_vld_o(wr_vld_o), .flush(flush), .rd_req(rd_req),
      .rd_idx(rd_idx), .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
      .rsp_pfn(rsp_pfn), .rsp_cat(rsp_cat), .rsp_dty(rsp_dty), .rsp_pv(rsp_pv),
      .rsp_unc(rsp_unc), .rb_vld(rb_vld), .rb_mask(rb_mask), .rb_tag(rb_tag),
      .rb_even(rb_even), .rb_odd(rb_odd)
   );

   typedef struct packed {
      logic [31:0] va;
      logic [7:0]  asid;
      logic        hit;
      logic [3:0]  idx;
      logic [19:0] pfn;
      logic [2:0]  cat;
      logic        dty;
      logic        pv;
      logic        unc;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      // R1 R2: slot 0, even half
      '{32'h0002_0000, 8'd5, 1'b1, 4'd0, 20'h111, 3'd3, 1'b1, 1'b1, 1'b0},
      // R5: slot 0, odd half
      '{32'h0002_1000, 8'd5, 1'b1, 4'd0, 20'h222, 3'd2, 1'b0, 1'b1, 1'b0},
      // R2: same tag, other address space -> slot 1
      '{32'h0002_1000, 8'd6, 1'b1, 4'd1, 20'h444, 3'd1, 1'b1, 1'b1, 1'b0},
      // R2: unknown address space, not global -> miss
      '{32'h0002_0000, 8'd7, 1'b0, 4'hF, 20'h0,   3'd0, 1'b0, 1'b0, 1'b0},
      // R2: global slot 2 ignores address space
      '{32'h0004_0000, 8'd7, 1'b1, 4'd2, 20'h555, 3'd1, 1'b0, 1'b1, 1'b0},
      // R3: slots 2 and 4 both match, lowest wins; odd half invalid
      '{32'h0004_1000, 8'd5, 1'b1, 4'd2, 20'h666, 3'd0, 1'b0, 1'b0, 1'b0},
      // R1 R5: masked slot 3, pick bit is va[14]=1 -> odd
      '{32'h0020_4000, 8'd5, 1'b1, 4'd3, 20'h888, 3'd0, 1'b0, 1'b1, 1'b0},
      // R5: va[12]=1 but va[14]=0 -> even
      '{32'h0020_3000, 8'd5, 1'b1, 4'd3, 20'h777, 3'd0, 1'b0, 1'b1, 1'b0},
      // R1: differs above the mask -> miss
      '{32'h0020_8000, 8'd5, 1'b0, 4'hF, 20'h0,   3'd0, 1'b0, 1'b0, 1'b0},
      // R9: hit in uncacheable region
      '{32'hA000_0000, 8'd5, 1'b1, 4'd5, 20'hAAA, 3'd2, 1'b1, 1'b1, 1'b1},
      // R9: miss still flags uncacheable
      '{32'hA000_0000, 8'd6, 1'b0, 4'hF, 20'h0,   3'd0, 1'b0, 1'b0, 1'b1},
      // R9: only bit 31 set -> cacheable
      '{32'h8000_0000, 8'd6, 1'b0, 4'hF, 20'h0,   3'd0, 1'b0, 1'b0, 1'b0}
   };

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] idx, input logic [18:0] vpn, input logic [18:0] msk,
                     input logic [7:0] asid, input logic g,
                     input logic [19:0] pe, input logic [19:0] po,
                     input logic [2:0] ce, input logic [2:0] co,
                     input logic de, input logic dd, input logic ve, input logic vo);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_mask = msk; wr_asid = asid;
      wr_glob = g; wr_pfn_e = pe; wr_pfn_o = po; wr_cat_e = ce; wr_cat_o = co;
      wr_dty_e = de; wr_dty_o = dd; wr_vld_e = ve; wr_vld_o = vo;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic look(input logic [31:0] va, input logic [7:0] asid);
      @(negedge clk);
      lk_req = 1'b1; lk_va = va; lk_asid = asid;
      @(negedge clk);
      lk_req = 1'b0;
   endtask

   task automatic rdb(input logic [3:0] idx);
      @(negedge clk);
      rd_req = 1'b1; rd_idx = idx;
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R8 R11: reset state
      chk("R11 rsp_vld after reset", rsp_vld, 0);
      chk("R8 rsp_hit after reset", rsp_hit, 0);
      chk("R10 rb_vld after reset", rb_vld, 0);
      rst_n = 1'b1;
      look(32'h0002_0000, 8'd5);
      chk("R11 rsp_vld after lookup", rsp_vld, 1);
      chk("R8 empty buffer misses", rsp_hit, 0);
      chk("R4 empty miss idx", rsp_idx, 4'hF);
      @(negedge clk);
      chk("R11 rsp_vld drops", rsp_vld, 0);

      // program slots
      wr(4'd0, 19'h00010, 19'h0, 8'd5, 1'b0, 20'h111, 20'h222, 3'd3, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1);
      wr(4'd1, 19'h00010, 19'h0, 8'd6, 1'b0, 20'h333, 20'h444, 3'd0, 3'd1, 1'b0, 1'b1, 1'b1, 1'b1);
      wr(4'd2, 19'h00020, 19'h0, 8'd9, 1'b1, 20'h555, 20'h666, 3'd1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
      wr(4'd3, 19'h00100, 19'h3, 8'd5, 1'b0, 20'h777, 20'h888, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1);
      wr(4'd4, 19'h00020, 19'h0, 8'd5, 1'b0, 20'h999, 20'h999, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1);
      wr(4'd5, 19'h50000, 19'h0, 8'd5, 1'b0, 20'hAAA, 20'hBBB, 3'd2, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1);
      // R8: slot 6 written with both valid bits clear
      wr(4'd6, 19'h00060, 19'h0, 8'd0, 1'b1, 20'hCCC, 20'hCCC, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      // R6: out-of-range writes; index 8 aliases slot 0 in its low bits
      wr(4'd8,  19'h00010, 19'h0, 8'd5, 1'b1, 20'hDEAD, 20'hDEAD, 3'd7, 3'd7, 1'b1, 1'b1, 1'b1, 1'b1);
      wr(4'd15, 19'h00030, 19'h0, 8'd5, 1'b1, 20'hBEEF, 20'hBEEF, 3'd7, 3'd7, 1'b1, 1'b1, 1'b1, 1'b1);

      for (int k = 0; k < NV; k++) begin
         look(VECS[k].va, VECS[k].asid);
         chk("R1 hit", rsp_hit, VECS[k].hit);
         chk("R4 idx", rsp_idx, VECS[k].idx);
         chk("R5 pfn", rsp_pfn, VECS[k].pfn);
         chk("R5 cat", rsp_cat, VECS[k].cat);
         chk("R5 dty", rsp_dty, VECS[k].dty);
         chk("R5 pv", rsp_pv, VECS[k].pv);
         chk("R9 unc", rsp_unc, VECS[k].unc);
      end

      // R6: tag written only through index 15 is absent
      look(32'h0006_0000, 8'd5);
      chk("R6 out-of-range write ignored", rsp_hit, 0);
      // R8: unoccupied slot 6 never matches even though global
      look(32'h000C_0000, 8'd0);
      chk("R8 unoccupied slot misses", rsp_hit, 0);

      // R10: readback layouts
      rdb(4'd0);
      chk("R10 rb_vld", rb_vld, 1);
      chk("R10 slot0 mask", rb_mask, 30'h0);
      chk("R10 slot0 tag", rb_tag, 30'h8005);
      chk("R10 slot0 even", rb_even, 26'h445E);
      chk("R10 slot0 odd", rb_odd, 26'h8892);
      rdb(4'd3);
      chk("R10 slot3 mask", rb_mask, 30'h1800);
      rdb(4'd2);
      chk("R10 slot2 even global", rb_even, 26'h1554B);
      chk("R10 slot2 odd global", rb_odd, 26'h19981);
      rdb(4'd9);
      chk("R10 out-of-range tag", rb_tag, 30'h0);
      chk("R10 out-of-range even", rb_even, 26'h0);

      // R7: flush with a simultaneous write
      @(negedge clk);
      flush = 1'b1; wr_en = 1'b1; wr_idx = 4'd6; wr_vpn = 19'h00040; wr_mask = '0;
      wr_asid = 8'd0; wr_glob = 1'b1; wr_vld_e = 1'b1; wr_vld_o = 1'b1; wr_pfn_e = 20'h4040;
      @(negedge clk);
      flush = 1'b0; wr_en = 1'b0;
      look(32'h0008_0000, 8'd0);
      chk("R7 write during flush dropped", rsp_hit, 0);
      look(32'h0002_0000, 8'd5);
      chk("R7 flushed slot0 misses", rsp_hit, 0);
      look(32'hA000_0000, 8'd5);
      chk("R7 flushed slot5 misses", rsp_hit, 0);

      // R12: replacement of an occupied slot
      wr(4'd0, 19'h00010, 19'h0, 8'd5, 1'b0, 20'h123, 20'h124, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1);
      look(32'h0002_0000, 8'd5);
      chk("R12 first mapping hit", rsp_hit, 1);
      chk("R12 first mapping pfn", rsp_pfn, 20'h123);
      wr(4'd0, 19'h00011, 19'h0, 8'd5, 1'b0, 20'h321, 20'h322, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1);
      look(32'h0002_0000, 8'd5);
      chk("R12 old mapping gone", rsp_hit, 0);
      look(32'h0002_2000, 8'd5);
      chk("R12 new mapping hit", rsp_hit, 1);
      chk("R12 new mapping pfn", rsp_pfn, 20'h321);
      chk("R4 replaced slot idx", rsp_idx, 4'd0);
      // R11: response holds between lookups
      repeat (2) @(negedge clk);
      chk("R11 response held", rsp_pfn, 20'h321);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule